// File: doc/BRIEF.md
# Crosstalk Victim/Aggressor Stress Pattern Generator

This block drives a parallel data bus with words chosen to make coupling between neighbouring lines as harmful as possible, and checks what returns on a looped-back receive bus. At any moment one line is the victim and every other line is an aggressor that switches at a common rate. The victim follows one of five relationships to the aggressors: switching with them, switching against them, switching every cycle, or being held high or held low. A full pass steps through every relationship on every line, at every aggressor rate from fastest to slowest.

Each received word is compared with the word sent a fixed number of cycles earlier. The first mismatch latches its relationship, victim line, rate and the bit-wise difference, so that one failing step can be run again on its own with a replay start. A single start pulse launches a run, and busy and done report its progress.

Top module: `xtalk_stress_gen`

## Requirements
- R1: After reset, busy, done and errFlag are 0, txData is 0 and failMode, failVictim, failRate and failXor are 0.
- R2: Within a step at rate setting r, the step lasts STEP_HALVES<<r cycles, numbered c from 0. Every non-victim bit of txData equals aggressor phase bit r of c, so the aggressors change value every 2^r cycles and start at 0.
- R3: The victim bit depends on the mode code: 0 equals the aggressor phase, 1 is its inverse, 2 equals bit 0 of c, 3 is constant 1, 4 is constant 0.
- R4: A normal pass runs the mode from 0 to 4 fastest, then the victim index from 0 to WIDTH-1, then the rate from 0 to NUM_RATES-1. The first word appears on txData one cycle after the clock edge that samples start, and the words follow one another with no gaps.
- R5: busy goes high at the edge that samples start. busy falls and done rises LOOP_LAT+1 cycles after the edge that launches the last word. done stays high until the next accepted start.
- R6: rxData is compared with the txData word from LOOP_LAT cycles earlier. Any difference sets errFlag, which stays set to the end of the run. A run with no difference leaves errFlag at 0.
- R7: On the first mismatch of a run, failMode, failVictim and failRate record the step of the word that failed, and failXor records rxData XOR that word. Later mismatches in the same run change none of them.
- R8: An accepted start clears errFlag, failXor and done. failMode, failVictim and failRate keep their values until a new failure is recorded.
- R9: A start with replay high sends only the step held in failMode, failVictim and failRate, once, and then finishes with the same done timing as R5.
- R10: start is ignored while busy is high, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a run when idle |
| replay | input | 1 | With start, repeat only the recorded failing step |
| rxData | input | WIDTH | Looped-back receive bus |
| txData | output | WIDTH | Stress pattern transmit bus |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, all words compared |
| errFlag | output | 1 | A mismatch was seen in this run |
| failMode | output | 3 | Mode code of the first failing word |
| failVictim | output | $clog2(WIDTH) | Victim index of the first failing word |
| failRate | output | $clog2(NUM_RATES) | Rate setting of the first failing word |
| failXor | output | WIDTH | Mismatch vector of the first failing word |

## Verification
A wrong step counter or ordering shows on txData at the next cycle, as a word that no longer matches the pattern predicted from the run's position. A mistake in the compare-pipeline depth or the capture gating shows only after the run ends, as recorded tags or a mismatch vector that point at the wrong step. For that reason, faults are placed at known words and the reported step is checked against them. A drain count that is off by one moves the done edge by one cycle, so done and busy are checked on every cycle of the drain.

// File: rtl/xts_pkg.sv
package xts_pkg;

  typedef enum logic [2:0] {
    MODE_EVEN = 3'd0,
    MODE_ODD  = 3'd1,
    MODE_FAST = 3'd2,
    MODE_HIGH = 3'd3,
    MODE_LOW  = 3'd4
  } modeT;

  typedef struct packed {
    logic launch;    // a pattern word is produced this cycle
    logic clearErr;  // accepted start: wipe error state
    logic aggrPh;    // aggressor phase for this cycle
    logic fastPh;    // every-cycle toggle phase
  } ctrlStrobeT;

endpackage

// File: rtl/xts_control.sv
module xts_control
  import xts_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int NUM_RATES   = 4,
  parameter int STEP_HALVES = 4,
  parameter int LOOP_LAT    = 3,
  localparam int VW = $clog2(WIDTH),
  localparam int RW = $clog2(NUM_RATES),
  localparam int CW = $clog2(STEP_HALVES << (NUM_RATES - 1)) + 1,
  localparam int DW = $clog2(LOOP_LAT + 1) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          replay,
  input  modeT          capMode,
  input  logic [VW-1:0] capVictim,
  input  logic [RW-1:0] capRate,
  output ctrlStrobeT    strobe,
  output modeT          curMode,
  output logic [VW-1:0] curVictim,
  output logic [RW-1:0] curRate,
  output logic          busy,
  output logic          done
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} stateT;

  stateT         state;
  modeT          modeQ;
  logic [VW-1:0] vicQ;
  logic [RW-1:0] rateQ;
  logic [CW-1:0] cycQ;
  logic [DW-1:0] drainQ;
  logic          doneQ;
  logic          replayQ;

  logic [CW-1:0] stepLen;
  logic          lastCyc;
  logic          lastStep;
  logic          startAcc;

  always_comb begin
    stepLen  = CW'(STEP_HALVES) << rateQ;
    lastCyc  = (cycQ == stepLen - 1'b1);
    lastStep = replayQ ||
               ((modeQ == MODE_LOW) && (vicQ == VW'(WIDTH - 1)) &&
                (rateQ == RW'(NUM_RATES - 1)));
    startAcc = start && (state == ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      modeQ   <= MODE_EVEN;
      vicQ    <= '0;
      rateQ   <= '0;
      cycQ    <= '0;
      drainQ  <= '0;
      doneQ   <= 1'b0;
      replayQ <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startAcc) begin
            state   <= ST_RUN;
            cycQ    <= '0;
            doneQ   <= 1'b0;
            replayQ <= replay;
            if (replay) begin
              modeQ <= capMode;
              vicQ  <= capVictim;
              rateQ <= capRate;
            end else begin
              modeQ <= MODE_EVEN;
              vicQ  <= '0;
              rateQ <= '0;
            end
          end
        end
        ST_RUN: begin
          if (lastCyc) begin
            cycQ <= '0;
            if (lastStep) begin
              state  <= ST_DRAIN;
              drainQ <= '0;
            end else if (modeQ == MODE_LOW) begin
              modeQ <= MODE_EVEN;
              if (vicQ == VW'(WIDTH - 1)) begin
                vicQ  <= '0;
                rateQ <= rateQ + 1'b1;
              end else begin
                vicQ <= vicQ + 1'b1;
              end
            end else begin
              modeQ <= modeT'(modeQ + 3'd1);
            end
          end else begin
            cycQ <= cycQ + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (drainQ == DW'(LOOP_LAT)) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end else begin
            drainQ <= drainQ + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.launch   = (state == ST_RUN);
    strobe.clearErr = startAcc;
    strobe.aggrPh   = cycQ[rateQ];
    strobe.fastPh   = cycQ[0];
  end

  assign curMode   = modeQ;
  assign curVictim = vicQ;
  assign curRate   = rateQ;
  assign busy      = (state != ST_IDLE);
  assign done      = doneQ;

  // R4: step tags stay inside their ranges while words are launched
  assert_tag_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> ((vicQ <= VW'(WIDTH - 1)) && (modeQ <= MODE_LOW) &&
                           (rateQ <= RW'(NUM_RATES - 1))));

  // R5: done is only reported once the block is idle again
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (state == ST_IDLE));

  // R10: a start inside a step does not restart the step counter
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_RUN) && start && !lastCyc) |=> (cycQ == $past(cycQ) + 1'b1));

endmodule

// File: rtl/xts_datapath.sv
module xts_datapath
  import xts_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int NUM_RATES = 4,
  parameter int LOOP_LAT  = 3,
  localparam int VW = $clog2(WIDTH),
  localparam int RW = $clog2(NUM_RATES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobe,
  input  modeT             curMode,
  input  logic [VW-1:0]    curVictim,
  input  logic [RW-1:0]    curRate,
  input  logic [WIDTH-1:0] rxData,
  output logic [WIDTH-1:0] txData,
  output logic             errFlag,
  output modeT             capMode,
  output logic [VW-1:0]    capVictim,
  output logic [RW-1:0]    capRate,
  output logic [WIDTH-1:0] capXor
);

  logic [WIDTH-1:0] nextWord;
  logic             victimBit;

  always_comb begin
    unique case (curMode)
      MODE_EVEN: victimBit = strobe.aggrPh;
      MODE_ODD:  victimBit = ~strobe.aggrPh;
      MODE_FAST: victimBit = strobe.fastPh;
      MODE_HIGH: victimBit = 1'b1;
      default:   victimBit = 1'b0;
    endcase
    for (int i = 0; i < WIDTH; i++) begin
      nextWord[i] = (VW'(i) == curVictim) ? victimBit : strobe.aggrPh;
    end
  end

  // stage 0 is the transmit register; stage LOOP_LAT lines up with rxData
  logic             pipeV [LOOP_LAT+1];
  logic [WIDTH-1:0] pipeD [LOOP_LAT+1];
  modeT             pipeM [LOOP_LAT+1];
  logic [VW-1:0]    pipeVi[LOOP_LAT+1];
  logic [RW-1:0]    pipeR [LOOP_LAT+1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeV[0]  <= 1'b0;
      pipeD[0]  <= '0;
      pipeM[0]  <= MODE_EVEN;
      pipeVi[0] <= '0;
      pipeR[0]  <= '0;
    end else begin
      pipeV[0]  <= strobe.launch;
      pipeD[0]  <= strobe.launch ? nextWord : '0;
      pipeM[0]  <= curMode;
      pipeVi[0] <= curVictim;
      pipeR[0]  <= curRate;
    end
  end

  for (genvar k = 1; k <= LOOP_LAT; k++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pipeV[k]  <= 1'b0;
        pipeD[k]  <= '0;
        pipeM[k]  <= MODE_EVEN;
        pipeVi[k] <= '0;
        pipeR[k]  <= '0;
      end else begin
        pipeV[k]  <= pipeV[k-1];
        pipeD[k]  <= pipeD[k-1];
        pipeM[k]  <= pipeM[k-1];
        pipeVi[k] <= pipeVi[k-1];
        pipeR[k]  <= pipeR[k-1];
      end
    end
  end

  logic [WIDTH-1:0] mism;
  assign mism = pipeV[LOOP_LAT] ? (rxData ^ pipeD[LOOP_LAT]) : '0;

  logic             errQ;
  modeT             capModeQ;
  logic [VW-1:0]    capVicQ;
  logic [RW-1:0]    capRateQ;
  logic [WIDTH-1:0] capXorQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errQ     <= 1'b0;
      capModeQ <= MODE_EVEN;
      capVicQ  <= '0;
      capRateQ <= '0;
      capXorQ  <= '0;
    end else if (strobe.clearErr) begin
      errQ    <= 1'b0;
      capXorQ <= '0;
    end else if ((mism != '0) && !errQ) begin
      errQ     <= 1'b1;
      capModeQ <= pipeM[LOOP_LAT];
      capVicQ  <= pipeVi[LOOP_LAT];
      capRateQ <= pipeR[LOOP_LAT];
      capXorQ  <= mism;
    end
  end

  assign txData    = pipeD[0];
  assign errFlag   = errQ;
  assign capMode   = capModeQ;
  assign capVictim = capVicQ;
  assign capRate   = capRateQ;
  assign capXor    = capXorQ;

  // R6: the error flag is sticky until a start clears it
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (errQ && !strobe.clearErr) |=> errQ);

  // R7: the first failure record never moves while the flag is set
  assert_capture_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (errQ && !strobe.clearErr) |=> ($stable(capModeQ) && $stable(capVicQ) &&
                                    $stable(capRateQ) && $stable(capXorQ)));

  // R7: a recorded failure always carries a non-empty mismatch vector
  assert_xor_nonzero_R7: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> (capXorQ != '0));

  // R8: clearing leaves no error behind on the next cycle
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearErr |=> (!errQ && (capXorQ == '0)));

endmodule

// File: rtl/xtalk_stress_gen.sv
module xtalk_stress_gen
  import xts_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int NUM_RATES   = 4,
  parameter int STEP_HALVES = 4,
  parameter int LOOP_LAT    = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic                         replay,
  input  logic [WIDTH-1:0]             rxData,
  output logic [WIDTH-1:0]             txData,
  output logic                         busy,
  output logic                         done,
  output logic                         errFlag,
  output logic [2:0]                   failMode,
  output logic [$clog2(WIDTH)-1:0]     failVictim,
  output logic [$clog2(NUM_RATES)-1:0] failRate,
  output logic [WIDTH-1:0]             failXor
);

  localparam int VW = $clog2(WIDTH);
  localparam int RW = $clog2(NUM_RATES);

  ctrlStrobeT    strobe;
  modeT          curMode;
  logic [VW-1:0] curVictim;
  logic [RW-1:0] curRate;
  modeT          capMode;

  xts_control #(
    .WIDTH(WIDTH), .NUM_RATES(NUM_RATES),
    .STEP_HALVES(STEP_HALVES), .LOOP_LAT(LOOP_LAT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .replay(replay),
    .capMode(capMode), .capVictim(failVictim), .capRate(failRate),
    .strobe(strobe), .curMode(curMode), .curVictim(curVictim),
    .curRate(curRate), .busy(busy), .done(done)
  );

  xts_datapath #(
    .WIDTH(WIDTH), .NUM_RATES(NUM_RATES), .LOOP_LAT(LOOP_LAT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curMode(curMode),
    .curVictim(curVictim), .curRate(curRate), .rxData(rxData),
    .txData(txData), .errFlag(errFlag), .capMode(capMode),
    .capVictim(failVictim), .capRate(failRate), .capXor(failXor)
  );

  assign failMode = capMode;

endmodule

// File: tb/sim_xtalk_stress_gen.sv
module sim_xtalk_stress_gen;

  localparam int W   = 8;
  localparam int NR  = 4;
  localparam int SH  = 4;
  localparam int LAT = 3;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         replay = 1'b0;
  logic [W-1:0] rxData;
  logic [W-1:0] txData;
  logic         busy, done, errFlag;
  logic [2:0]   failMode;
  logic [2:0]   failVictim;
  logic [1:0]   failRate;
  logic [W-1:0] failXor;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xtalk_stress_gen #(.WIDTH(W), .NUM_RATES(NR), .STEP_HALVES(SH), .LOOP_LAT(LAT)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .replay(replay), .rxData(rxData),
    .txData(txData), .busy(busy), .done(done), .errFlag(errFlag),
    .failMode(failMode), .failVictim(failVictim), .failRate(failRate),
    .failXor(failXor)
  );

  // loopback with fault injection keyed to the word index
  int           curIdx = -1;
  logic [W-1:0] lbD [LAT];
  int           lbI [LAT];
  bit           injAOn = 0, injBOn = 0;
  int           injAIdx = 0, injBIdx = 0;
  logic [W-1:0] injAMask = '0, injBMask = '0;

  always @(posedge clk) begin
    lbD[0] <= txData;
    lbI[0] <= curIdx;
    for (int k = 1; k < LAT; k++) begin
      lbD[k] <= lbD[k-1];
      lbI[k] <= lbI[k-1];
    end
  end

  always_comb begin
    rxData = lbD[LAT-1];
    if (injAOn && lbI[LAT-1] == injAIdx) rxData = rxData ^ injAMask;
    if (injBOn && lbI[LAT-1] == injBIdx) rxData = rxData ^ injBMask;
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expWord(int m, int v, int r, int c);
    logic a, vb;
    logic [W-1:0] w;
    a = ((c >> r) & 1) != 0;
    case (m)
      0: vb = a;
      1: vb = !a;
      2: vb = (c & 1) != 0;
      3: vb = 1'b1;
      default: vb = 1'b0;
    endcase
    w = {W{a}};
    w[v] = vb;
    return w;
  endfunction

  function automatic int stepBase(int r, int v, int m);
    int b = 0;
    for (int q = 0; q < r; q++) b += W * 5 * (SH << q);
    return b + (v * 5 + m) * (SH << r);
  endfunction

  task automatic runSeq(input bit rep, input int rr, input int vv, input int mm);
    int j = 0;
    int bad [5];
    int timingBad = 0;
    logic [W-1:0] e;
    for (int m = 0; m < 5; m++) bad[m] = 0;
    @(negedge clk); start = 1'b1; replay = rep;
    @(negedge clk); start = 1'b0; replay = 1'b0;
    chk(busy == 1'b1 && done == 1'b0 && errFlag == 1'b0 && failXor == '0,
        "R5 R8 busy set, done/errFlag/failXor cleared after start",
        {busy, done, errFlag, failXor}, {4'b1000, 8'h00});
    for (int r = 0; r < NR; r++)
      for (int v = 0; v < W; v++)
        for (int m = 0; m < 5; m++) begin
          if (rep && !(r == rr && v == vv && m == mm)) continue;
          for (int c = 0; c < (SH << r); c++) begin
            @(negedge clk);
            curIdx = stepBase(r, v, m) + c;
            e = expWord(m, v, r, c);
            if (txData !== e) bad[m]++;
            if (!rep) begin
              if (j == 100) start = 1'b1;
              if (j == 101) start = 1'b0;
              if (j == 102)
                chk(txData === e && busy, "R10 start during run ignored", txData, e);
            end
            j++;
          end
        end
    for (int k = 1; k <= LAT + 1; k++) begin
      @(negedge clk);
      curIdx = -1;
      if (busy !== (k <= LAT) || done !== (k == LAT + 1)) timingBad++;
      if (txData !== '0) timingBad++;
    end
    for (int m = 0; m < 5; m++)
      chk(bad[m] == 0, $sformatf("R2 R3 R4 words in mode %0d", m), bad[m], 0);
    chk(timingBad == 0, "R5 done/busy timing after last word", timingBad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && errFlag == 0 && txData == '0 && failMode == 0 &&
        failVictim == 0 && failRate == 0 && failXor == '0, "R1 reset state",
        {busy, done, errFlag, txData, failMode, failVictim, failRate, failXor}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // full pass with two injected faults; the first must be kept
    injAOn = 1; injAIdx = stepBase(1, 5, 1) + 3; injAMask = 8'h24;
    injBOn = 1; injBIdx = stepBase(2, 0, 3) + 0; injBMask = 8'h80;
    runSeq(1'b0, 0, 0, 0);
    chk(errFlag == 1'b1, "R6 mismatch sets errFlag", errFlag, 1);
    chk(failMode == 3'd1, "R7 failMode of first fault", failMode, 1);
    chk(failVictim == 3'd5, "R7 failVictim of first fault", failVictim, 5);
    chk(failRate == 2'd1, "R7 failRate of first fault", failRate, 1);
    chk(failXor == 8'h24, "R7 failXor of first fault", failXor, 8'h24);
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R5 done holds while idle", {done, busy}, 2'b10);
    injAOn = 0; injBOn = 0;

    // replay of the recorded step, clean loopback
    runSeq(1'b1, 1, 5, 1);
    chk(errFlag == 1'b0 && failXor == '0, "R8 R6 clean replay has no error",
        {errFlag, failXor}, 0);
    chk(failMode == 3'd1 && failVictim == 3'd5 && failRate == 2'd1,
        "R8 R9 recorded step retained", {failMode, failVictim, failRate}, {3'd1, 3'd5, 2'd1});

    // replay with a fault on its last word
    injAOn = 1; injAIdx = stepBase(1, 5, 1) + 7; injAMask = 8'h01;
    runSeq(1'b1, 1, 5, 1);
    chk(errFlag == 1'b1 && failXor == 8'h01, "R9 R7 fault caught during replay",
        {errFlag, failXor}, {1'b1, 8'h01});
    chk(failMode == 3'd1 && failVictim == 3'd5 && failRate == 2'd1,
        "R9 replay tags", {failMode, failVictim, failRate}, {3'd1, 3'd5, 2'd1});
    injAOn = 0;

    // clean full pass
    runSeq(1'b0, 0, 0, 0);
    chk(errFlag == 1'b0 && failXor == '0, "R6 clean pass reports no error",
        {errFlag, failXor}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule